// File: doc/BRIEF.md
# Read-After-Write Stall Interlock

This block decides, every cycle, whether the instruction sitting in the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) may proceed. There are no bypass paths. A value that an older instruction produces can be used only once that instruction has reached writeback. So a younger instruction that reads the register is kept in decode for as long as its producer is still in execute or memory. While it waits, the program counter and the fetch/decode register are frozen, and the block loads an all-zero no-op into the decode/execute register with its write enable cleared.

The block keeps its own copy of the destination fields of the two older slots, execute and memory, so it needs only the decode-stage fields as input. It owns the control part of the decode/execute register, which is the instruction word, destination, write enable and valid, and it drives those fields toward the datapath. The register file is taken to write in the first half of a cycle and read in the second half, so a producer that has reached writeback never causes a stall. The interface is plain control rather than a valid/ready stream. The hold outputs are the only back-pressure, and the stages after decode never stall. A consumer that reads the result of the instruction just ahead of it waits two cycles. It enters execute in the cycle after its producer's writeback.

Top module: `raw_interlock`

## Requirements
- R1: While reset is asserted and directly after it, the execute slot is empty: ex_valid=0, ex_dst_we=0, ex_dst=0, ex_word=0, and no hold or bubble is raised.
- R2: A valid decode instruction whose read source (rs with id_rs_rd=1, or rt with id_rt_rd=1) equals the destination of a valid, writing instruction now in execute raises pc_hold, ifid_hold and idex_bubble together in that same cycle.
- R3: The same stall is raised when the matching producer is in the memory stage.
- R4: A producer that has moved past memory causes no stall. A consumer directly behind its producer waits exactly two cycles, and a consumer with one unrelated instruction between them waits one cycle.
- R5: Register number 0 never causes a stall, whatever is written to it or read from it.
- R6: A source field whose read flag is 0 is ignored in the comparison.
- R7: An older slot whose write enable is 0 or whose valid flag is 0 causes no stall.
- R8: In the cycle after a stall, the execute slot holds a bubble: ex_word is all zero (the no-op encoding), ex_valid=0, ex_dst_we=0 and ex_dst=0.
- R9: In the cycle after a valid decode instruction is accepted without a stall, ex_valid=1 and ex_word, ex_dst and ex_dst_we equal the accepted instruction's id_word, id_dst and id_dst_we.
- R10: When id_valid=0 no stall is raised, and the next cycle's execute slot is empty, with an all-zero word.
- R11: When the decode instruction depends on producers in both execute and memory, the stall lasts until neither slot matches. No stall run is ever longer than two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_word | input | WORD_W | Instruction word in decode |
| id_rs | input | REG_W | First source register number |
| id_rt | input | REG_W | Second source register number |
| id_rs_rd | input | 1 | Decode instruction reads id_rs |
| id_rt_rd | input | 1 | Decode instruction reads id_rt |
| id_dst | input | REG_W | Destination register number of the decode instruction |
| id_dst_we | input | 1 | Decode instruction writes id_dst |
| pc_hold | output | 1 | Keep the program counter unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged this cycle |
| idex_bubble | output | 1 | Load a no-op into the decode/execute register this cycle |
| ex_valid | output | 1 | Execute slot holds a real instruction |
| ex_word | output | WORD_W | Instruction word in execute (all zero for a bubble) |
| ex_dst | output | REG_W | Destination register number in execute |
| ex_dst_we | output | 1 | Execute instruction writes ex_dst |

## Verification
The two comparisons can hit in the same cycle. This happens when a decode instruction reads one register written by the instruction in execute and another written by the instruction in memory. The bench provokes it by issuing two writers to different registers, then a reader of both. It judges the outcome by a total of exactly two stall cycles, with the reference model compared on every clock. It also provokes a stall and a new acceptance on consecutive cycles in a long pseudo-random stream over a small register range, so that bubbles, holds and fresh loads overlap in every order.

// File: rtl/raw_interlock_pkg.sv
package raw_interlock_pkg;

  // Stall controls toward fetch, decode and the decode/execute register.
  typedef struct packed {
    logic hold_pc;
    logic hold_ifid;
    logic bubble;
  } stall_ctl_t;

endpackage

// File: rtl/raw_src_match.sv
// Compares the read sources of the decode instruction with one older slot.
module raw_src_match #(
  parameter int REG_W = 5
) (
  input  logic             slot_valid,
  input  logic             slot_we,
  input  logic [REG_W-1:0] slot_dst,
  input  logic [REG_W-1:0] rs,
  input  logic [REG_W-1:0] rt,
  input  logic             rs_rd,
  input  logic             rt_rd,
  output logic             hit
);
  logic writes_real;
  logic rs_eq;
  logic rt_eq;

  always_comb begin
    writes_real = slot_valid && slot_we && (slot_dst != '0);
    rs_eq       = rs_rd && (rs == slot_dst);
    rt_eq       = rt_rd && (rt == slot_dst);
    hit         = writes_real && (rs_eq || rt_eq);
  end
endmodule

// File: rtl/raw_shadow_slot.sv
// One stage of the destination shadow: valid, write enable and register number.
module raw_shadow_slot #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_we,
  input  logic [REG_W-1:0] in_dst,
  output logic             out_valid,
  output logic             out_we,
  output logic [REG_W-1:0] out_dst
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_we    <= 1'b0;
      out_dst   <= '0;
    end else begin
      out_valid <= in_valid;
      out_we    <= in_we;
      out_dst   <= in_dst;
    end
  end
endmodule

// File: rtl/raw_stall_decide.sv
// Reduces the per-slot hits to the stall controls.
module raw_stall_decide
  import raw_interlock_pkg::*;
#(
  parameter int SLOTS = 2
) (
  input  logic             id_valid,
  input  logic [SLOTS-1:0] hits,
  output stall_ctl_t       ctl
);
  logic stall;

  always_comb begin
    stall         = id_valid && (|hits);
    ctl.hold_pc   = stall;
    ctl.hold_ifid = stall;
    ctl.bubble    = stall;
  end
endmodule

// File: rtl/raw_interlock.sv
module raw_interlock
  import raw_interlock_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int WORD_W    = 32,
  parameter int HAZ_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic [WORD_W-1:0] id_word,
  input  logic [REG_W-1:0]  id_rs,
  input  logic [REG_W-1:0]  id_rt,
  input  logic              id_rs_rd,
  input  logic              id_rt_rd,
  input  logic [REG_W-1:0]  id_dst,
  input  logic              id_dst_we,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic              idex_bubble,
  output logic              ex_valid,
  output logic [WORD_W-1:0] ex_word,
  output logic [REG_W-1:0]  ex_dst,
  output logic              ex_dst_we
);
  localparam int LAST = HAZ_DEPTH - 1;

  stall_ctl_t ctl;
  logic       accept;

  logic [HAZ_DEPTH-1:0] sin_valid;
  logic [HAZ_DEPTH-1:0] sin_we;
  logic [REG_W-1:0]     sin_dst  [HAZ_DEPTH];
  logic [HAZ_DEPTH-1:0] sout_valid;
  logic [HAZ_DEPTH-1:0] sout_we;
  logic [REG_W-1:0]     sout_dst [HAZ_DEPTH];
  logic [HAZ_DEPTH-1:0] hits;
  logic [WORD_W-1:0]    word_q;

  assign accept = id_valid && !ctl.bubble;

  // Slot 0 is the decode/execute register: the decode fields or a bubble.
  assign sin_valid[0] = accept;
  assign sin_we[0]    = accept && id_dst_we;
  assign sin_dst[0]   = accept ? id_dst : '0;

  for (genvar k = 0; k < HAZ_DEPTH; k++) begin : g_slot
    if (k > 0) begin : g_chain
      assign sin_valid[k] = sout_valid[k-1];
      assign sin_we[k]    = sout_we[k-1];
      assign sin_dst[k]   = sout_dst[k-1];
    end

    raw_shadow_slot #(.REG_W(REG_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (sin_valid[k]),
      .in_we    (sin_we[k]),
      .in_dst   (sin_dst[k]),
      .out_valid(sout_valid[k]),
      .out_we   (sout_we[k]),
      .out_dst  (sout_dst[k])
    );

    raw_src_match #(.REG_W(REG_W)) u_match (
      .slot_valid(sout_valid[k]),
      .slot_we   (sout_we[k]),
      .slot_dst  (sout_dst[k]),
      .rs        (id_rs),
      .rt        (id_rt),
      .rs_rd     (id_rs_rd),
      .rt_rd     (id_rt_rd),
      .hit       (hits[k])
    );
  end

  raw_stall_decide #(.SLOTS(HAZ_DEPTH)) u_decide (
    .id_valid(id_valid),
    .hits    (hits),
    .ctl     (ctl)
  );

  // Instruction word of the decode/execute register; a bubble is all zero.
  always_ff @(posedge clk) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= accept ? id_word : '0;
  end

  assign pc_hold     = ctl.hold_pc;
  assign ifid_hold   = ctl.hold_ifid;
  assign idex_bubble = ctl.bubble;
  assign ex_valid    = sout_valid[0];
  assign ex_word     = word_q;
  assign ex_dst      = sout_dst[0];
  assign ex_dst_we   = sout_we[0];

  // The last shadow slot leaves for writeback, where it no longer matters.
  logic unused_tail;
  assign unused_tail = ^{sout_valid[LAST], sout_we[LAST], sout_dst[LAST]};
endmodule

// File: rtl/raw_interlock_chk.sv
module raw_interlock_chk #(
  parameter int REG_W     = 5,
  parameter int WORD_W    = 32,
  parameter int HAZ_DEPTH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              id_valid,
  input logic [WORD_W-1:0] id_word,
  input logic [REG_W-1:0]  id_rs,
  input logic [REG_W-1:0]  id_rt,
  input logic              id_rs_rd,
  input logic              id_rt_rd,
  input logic [REG_W-1:0]  id_dst,
  input logic              id_dst_we,
  input logic              pc_hold,
  input logic              ifid_hold,
  input logic              idex_bubble,
  input logic              ex_valid,
  input logic [WORD_W-1:0] ex_word,
  input logic [REG_W-1:0]  ex_dst,
  input logic              ex_dst_we
);
  int run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)       run_len <= 0;
    else if (pc_hold) run_len <= run_len + 1;
    else              run_len <= 0;
  end

  AST_BUBBLE_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |=> (!ex_valid && ex_word == '0 && !ex_dst_we && ex_dst == '0)); // R8

  AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && !pc_hold) |=> (ex_valid && ex_word == $past(id_word)
                                && ex_dst == $past(id_dst) && ex_dst_we == $past(id_dst_we))); // R9

  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> !pc_hold); // R10

  AST_ZERO_REG_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ((!id_rs_rd || id_rs == '0) && (!id_rt_rd || id_rt == '0)) |-> !pc_hold); // R5

  AST_STALL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= HAZ_DEPTH); // R11

  AST_HOLDS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold |-> (ifid_hold && idex_bubble)); // R2
endmodule

bind raw_interlock raw_interlock_chk #(
  .REG_W(REG_W), .WORD_W(WORD_W), .HAZ_DEPTH(HAZ_DEPTH)
) u_chk (.*);

// File: tb/raw_interlock_test.sv
module raw_interlock_test;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W  = 5;
  localparam int WORD_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              id_valid = 1'b0;
  logic [WORD_W-1:0] id_word = '0;
  logic [REG_W-1:0]  id_rs = '0;
  logic [REG_W-1:0]  id_rt = '0;
  logic              id_rs_rd = 1'b0;
  logic              id_rt_rd = 1'b0;
  logic [REG_W-1:0]  id_dst = '0;
  logic              id_dst_we = 1'b0;
  logic              pc_hold, ifid_hold, idex_bubble, ex_valid, ex_dst_we;
  logic [WORD_W-1:0] ex_word;
  logic [REG_W-1:0]  ex_dst;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  bit last_stall;

  // Reference model: execute and memory slots of the shadow.
  bit          m_v[2];
  bit          m_we[2];
  int          m_dst[2];
  logic [31:0] m_word;

  raw_interlock uut (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_word(id_word),
    .id_rs(id_rs), .id_rt(id_rt), .id_rs_rd(id_rs_rd), .id_rt_rd(id_rt_rd),
    .id_dst(id_dst), .id_dst_we(id_dst_we), .pc_hold(pc_hold), .ifid_hold(ifid_hold),
    .idex_bubble(idex_bubble), .ex_valid(ex_valid), .ex_word(ex_word),
    .ex_dst(ex_dst), .ex_dst_we(ex_dst_we)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit model_stall(bit v, int rs, int rt, bit rsu, bit rtu);
    bit s = 0;
    for (int k = 0; k < 2; k++)
      if (m_v[k] && m_we[k] && m_dst[k] != 0 &&
          ((rsu && rs == m_dst[k]) || (rtu && rt == m_dst[k])))
        s = 1;
    return v && s;
  endfunction

  // One clock: drive at the falling edge, compare, then advance the model.
  task automatic step(input bit v, input logic [31:0] w, input int rs, input int rt,
                      input bit rsu, input bit rtu, input int dst, input bit we);
    bit s;
    @(negedge clk);
    id_valid = v; id_word = w; id_rs = REG_W'(rs); id_rt = REG_W'(rt);
    id_rs_rd = rsu; id_rt_rd = rtu; id_dst = REG_W'(dst); id_dst_we = we;
    #1;
    s = model_stall(v, rs, rt, rsu, rtu);
    check("R2 pc_hold", 64'(pc_hold), 64'(s));
    check("R2 ifid_hold", 64'(ifid_hold), 64'(s));
    check("R8 idex_bubble", 64'(idex_bubble), 64'(s));
    check("R9 ex_valid", 64'(ex_valid), 64'(m_v[0]));
    check("R9 ex_word", 64'(ex_word), 64'(m_word));
    check("R9 ex_dst", 64'(ex_dst), 64'(m_dst[0]));
    check("R9 ex_dst_we", 64'(ex_dst_we), 64'(m_we[0]));
    last_stall = s;
    @(posedge clk);
    m_v[1] = m_v[0]; m_we[1] = m_we[0]; m_dst[1] = m_dst[0];
    if (v && !s) begin
      m_v[0] = 1; m_we[0] = we; m_dst[0] = dst; m_word = w;
    end else begin
      m_v[0] = 0; m_we[0] = 0; m_dst[0] = 0; m_word = '0;
    end
  endtask

  task automatic issue(input logic [31:0] w, input int rs, input int rt, input bit rsu,
                       input bit rtu, input int dst, input bit we, output int nst);
    nst = 0;
    do begin
      step(1, w, rs, rt, rsu, rtu, dst, we);
      if (last_stall) nst++;
    end while (last_stall && nst < 8);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    int n;
    for (int k = 0; k < 2; k++) begin m_v[k] = 0; m_we[k] = 0; m_dst[k] = 0; end
    m_word = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset ex_valid", 64'(ex_valid), 64'd0);
    check("R1 reset ex_word", 64'(ex_word), 64'd0);
    check("R1 reset hold", 64'(pc_hold), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    idle(1);

    // R4: back-to-back dependency waits two cycles.
    issue(32'h0129_4020, 9, 9, 1, 1, 8, 1, n);
    issue(32'h0108_5022, 8, 8, 1, 1, 10, 1, n);
    check("R4 back-to-back stall cycles", 64'(n), 64'd2);
    idle(3);

    // R3: producer in memory only, one cycle.
    issue(32'h1111_0001, 1, 2, 1, 1, 12, 1, n);
    issue(32'h1111_0002, 3, 4, 1, 1, 13, 1, n);
    issue(32'h1111_0003, 12, 4, 1, 1, 14, 1, n);
    check("R3 memory-stage stall cycles", 64'(n), 64'd1);
    idle(3);

    // R4: producer already past memory, no stall.
    issue(32'h2222_0001, 1, 2, 1, 1, 15, 1, n);
    issue(32'h2222_0002, 3, 4, 1, 1, 16, 1, n);
    issue(32'h2222_0003, 3, 4, 1, 1, 17, 1, n);
    issue(32'h2222_0004, 15, 15, 1, 1, 18, 1, n);
    check("R4 writeback producer no stall", 64'(n), 64'd0);
    idle(3);

    // R5: register zero.
    issue(32'h3333_0001, 1, 2, 1, 1, 0, 1, n);
    issue(32'h0000_0000, 0, 0, 1, 1, 0, 1, n);
    check("R5 register zero no stall", 64'(n), 64'd0);
    idle(3);

    // R6: unused source field.
    issue(32'h4444_0001, 1, 2, 1, 1, 5, 1, n);
    issue(32'h4444_0002, 1, 5, 1, 0, 6, 1, n);
    check("R6 unread rt ignored", 64'(n), 64'd0);
    idle(3);

    // R7: producer that does not write.
    issue(32'h5555_0001, 1, 2, 1, 1, 7, 0, n);
    issue(32'h5555_0002, 7, 7, 1, 1, 8, 1, n);
    check("R7 non-writing producer ignored", 64'(n), 64'd0);
    idle(3);

    // R10: idle decode slot matching a producer.
    issue(32'h6666_0001, 1, 2, 1, 1, 9, 1, n);
    step(0, 32'h6666_0002, 9, 9, 1, 1, 3, 1);
    check("R10 idle slot no stall", 64'(last_stall), 64'd0);
    idle(3);

    // R11: hits in execute and memory in the same cycle.
    issue(32'h7777_0001, 1, 2, 1, 1, 20, 1, n);
    issue(32'h7777_0002, 3, 4, 1, 1, 21, 1, n);
    issue(32'h7777_0003, 20, 21, 1, 1, 22, 1, n);
    check("R11 double dependency stall cycles", 64'(n), 64'd2);
    idle(3);

    // Mixed stream over a small register range.
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 5) == 0) idle(1);
      else issue($urandom, $urandom_range(0, 5), $urandom_range(0, 5),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 $urandom_range(0, 5), 1'($urandom_range(0, 1)), n);
      check("R11 stall run bounded", 64'(n <= 2), 64'd1);
    end
    idle(3);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule